// File: doc/BRIEF.md
# Nibble-Pair Byte Reassembly Receiver

This block sits behind a radio receiver whose data path is only four bits wide. The transmitter sends each 8-bit character as two nibbles, one after the other. The receiver drives the nibbles onto a 4-bit bus that has no clock. An all-zero value on that bus means the link is idle. This block takes that bus and rebuilds the characters, one byte at a time, in the system clock domain.

The bus first goes through a flop-chain synchronizer. A qualifier then accepts a nibble only when the bus has held one non-zero value for a programmable number of consecutive clocks. It accepts each held value once, and the bus must return to idle before the next nibble can be accepted. This filters out the passing codes the bus shows while it switches from one value to another.

A pairing stage then treats the first accepted nibble as the low half and the second as the high half. It emits the assembled byte with a single-cycle strobe. If the high half does not come in time, the stage drops the half-received byte and reports a framing error. A consumer that does not acknowledge bytes quickly enough causes a sticky overrun flag.

Top module: `nibble_byte_rx`

## Requirements
- R1: `nib_in` passes through a two-flop synchronizer. A byte's `byte_valid` rises exactly STABLE_CYCLES+3 rising clock edges after its high nibble appears on `nib_in` (previously idle).
- R2: The first accepted nibble of a pair becomes `byte_out[3:0]` and the second becomes `byte_out[7:4]`.
- R3: The value 4'h0 on `nib_in` is idle and is never accepted as a nibble, however long it is held.
- R4: A non-zero value is accepted only after it has been seen unchanged on the synchronized bus for STABLE_CYCLES (default 8) consecutive clocks. Shorter runs, including intermediate codes while the bus switches, are ignored.
- R5: A value held for any length of time is accepted once. After an acceptance, no further nibble is accepted until the bus has been idle. This holds even if the bus changes directly to another non-zero value.
- R6: If no high nibble is accepted within PAIR_TIMEOUT (default 512) clocks after the low nibble, `framing_error` pulses for one clock and the stored low nibble is discarded. The next accepted nibble is then treated as a low half.
- R7: `byte_valid` is high for exactly one clock per assembled byte, with `byte_out` valid in that cycle.
- R8: A byte counts as taken in any cycle in which `byte_ready` is high, including the cycle of its own `byte_valid`. If `byte_valid` fires while an earlier byte is still untaken and `byte_ready` is low, `overrun` rises on the next clock and stays high until reset.
- R9: Synchronous active-high `rst` clears the pairing state, the stability counter, `byte_out`, `byte_valid`, `framing_error` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| nib_in | input | 4 | Asynchronous nibble bus from the radio receiver, 0 means idle |
| byte_ready | input | 1 | Consumer takes the current byte in any cycle this is high |
| byte_out | output | 8 | Last assembled byte, low nibble in bits 3:0 |
| byte_valid | output | 1 | One-clock strobe for a new byte |
| framing_error | output | 1 | One-clock pulse when a low nibble times out |
| overrun | output | 1 | Sticky flag: a byte arrived before the previous one was taken |

## Verification
Some properties are checked by assertions on every cycle. An accepted nibble is never zero, and acceptances never occur on back-to-back clocks. A byte only ever completes from the waiting-for-high state. The valid and framing strobes last one clock. Once `overrun` is set it stays set, and it only rises after an unacknowledged strobe. Other behaviour can only be shown by the bench's scenarios: settling filters out codes that pass through briefly, a long hold yields one nibble, a value change with no idle in between is rejected, the exact latency from the bus to the strobe, and recovery after a timeout. For these the bench compares the decoded bytes against the queue of bytes it sent.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int NIB_W = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef enum logic {
    PAIR_LOW  = 1'b0,
    PAIR_HIGH = 1'b1
  } pair_state_t;
endpackage

// File: rtl/nib_sync.sv
module nib_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= async_in;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nib_settle.sv
module nib_settle #(
  parameter int W             = 4,
  parameter int STABLE_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_in,
  output logic         strobe,
  output logic [W-1:0] value
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STABLE_CYCLES);

  logic [W-1:0]  last_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          armed_q;
  logic          is_idle, changed, fire;

  always_comb begin
    is_idle = (sync_in == '0);
    changed = (sync_in != last_q);
    if (changed)             cnt_n = CW'(1);
    else if (cnt_q == LIMIT) cnt_n = LIMIT;
    else                     cnt_n = cnt_q + CW'(1);
    fire = armed_q && !is_idle && (cnt_n == LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b1;
      strobe  <= 1'b0;
      value   <= '0;
    end else begin
      strobe <= fire;
      if (fire) value <= sync_in;
      last_q <= sync_in;
      if (is_idle) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else begin
        cnt_q <= cnt_n;
        if (fire) armed_q <= 1'b0;
      end
    end
  end

  assert_nonzero_nibble_R3: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (value != '0));

  assert_single_accept_R5: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
endmodule

// File: rtl/nib_pair.sv
module nib_pair
  import nib_pkg::*;
#(
  parameter int PAIR_TIMEOUT = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nib_strobe,
  input  logic [NIB_W-1:0]  nib_value,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_valid,
  output logic              framing_error
);
  localparam int TW = (PAIR_TIMEOUT > 2) ? $clog2(PAIR_TIMEOUT) : 1;
  localparam logic [TW-1:0] LAST_TICK = TW'(PAIR_TIMEOUT - 1);

  pair_state_t      state_q;
  logic [NIB_W-1:0] low_q;
  logic [TW-1:0]    timer_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= PAIR_LOW;
      low_q         <= '0;
      timer_q       <= '0;
      byte_out      <= '0;
      byte_valid    <= 1'b0;
      framing_error <= 1'b0;
    end else begin
      byte_valid    <= 1'b0;
      framing_error <= 1'b0;
      case (state_q)
        PAIR_LOW: begin
          if (nib_strobe) begin
            low_q   <= nib_value;
            timer_q <= '0;
            state_q <= PAIR_HIGH;
          end
        end
        PAIR_HIGH: begin
          if (nib_strobe) begin
            byte_out   <= {nib_value, low_q};
            byte_valid <= 1'b1;
            state_q    <= PAIR_LOW;
          end else if (timer_q == LAST_TICK) begin
            framing_error <= 1'b1;
            state_q       <= PAIR_LOW;
          end else begin
            timer_q <= timer_q + TW'(1);
          end
        end
        default: state_q <= PAIR_LOW;
      endcase
    end
  end

  assert_high_follows_low_R2: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(state_q == PAIR_HIGH));

  assert_valid_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);

  assert_timeout_source_R6: assert property (@(posedge clk) disable iff (rst)
    framing_error |-> $past(state_q == PAIR_HIGH && !nib_strobe));

  assert_error_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    framing_error |=> !framing_error);
endmodule

// File: rtl/nib_overrun.sv
module nib_overrun (
  input  logic clk,
  input  logic rst,
  input  logic byte_valid,
  input  logic byte_ready,
  output logic overrun
);
  logic pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (byte_valid) pending_q <= !byte_ready;
      else if (byte_ready) pending_q <= 1'b0;
      if (byte_valid && pending_q && !byte_ready) overrun <= 1'b1;
    end
  end

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(byte_valid && !byte_ready));
endmodule

// File: rtl/nibble_byte_rx.sv
module nibble_byte_rx
  import nib_pkg::*;
#(
  parameter int STABLE_CYCLES = 8,
  parameter int PAIR_TIMEOUT  = 512,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NIB_W-1:0]  nib_in,
  input  logic              byte_ready,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_valid,
  output logic              framing_error,
  output logic              overrun
);
  logic [NIB_W-1:0] nib_sync_w;
  logic             acc_strobe;
  logic [NIB_W-1:0] acc_value;

  nib_sync #(.W(NIB_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(nib_in), .sync_out(nib_sync_w)
  );

  nib_settle #(.W(NIB_W), .STABLE_CYCLES(STABLE_CYCLES)) u_settle (
    .clk(clk), .rst(rst), .sync_in(nib_sync_w),
    .strobe(acc_strobe), .value(acc_value)
  );

  nib_pair #(.PAIR_TIMEOUT(PAIR_TIMEOUT)) u_pair (
    .clk(clk), .rst(rst), .nib_strobe(acc_strobe), .nib_value(acc_value),
    .byte_out(byte_out), .byte_valid(byte_valid), .framing_error(framing_error)
  );

  nib_overrun u_ovr (
    .clk(clk), .rst(rst), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .overrun(overrun)
  );
endmodule

// File: tb/sim_nibble_byte_rx.sv
module sim_nibble_byte_rx;
  localparam int CLK_PERIOD = 10;
  localparam int STABLE     = 8;
  localparam int TIMEOUT    = 512;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] nib_in = 4'h0;
  logic       byte_ready = 1'b1;
  logic [7:0] byte_out;
  logic       byte_valid, framing_error, overrun;

  int vectors = 0;
  int fails = 0;
  int ferr_count = 0;
  logic [7:0] exp_q[$];
  logic prev_bv = 1'b0;
  logic prev_fe = 1'b0;

  nibble_byte_rx #(.STABLE_CYCLES(STABLE), .PAIR_TIMEOUT(TIMEOUT)) u0 (
    .clk(clk), .rst(rst), .nib_in(nib_in), .byte_ready(byte_ready),
    .byte_out(byte_out), .byte_valid(byte_valid),
    .framing_error(framing_error), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected bytes as the design produces them
  always @(negedge clk) begin
    if (rst) begin
      prev_bv = 1'b0;
      prev_fe = 1'b0;
    end else begin
      if (byte_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R5 unexpected byte", byte_out, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(byte_out == e, "R2 byte value", byte_out, e);
        end
        check(!prev_bv, "R7 strobe width", 2, 1);
      end
      if (framing_error) begin
        ferr_count++;
        check(!prev_fe, "R6 error width", 2, 1);
      end
      prev_bv = byte_valid;
      prev_fe = framing_error;
    end
  end

  task automatic hold(input logic [3:0] n, input int cycles);
    nib_in = n;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    exp_q.push_back(b);
    hold(b[3:0], 20); hold(4'h0, 12);
    hold(b[7:4], 20); hold(4'h0, 12);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(byte_valid == 0 && framing_error == 0 && overrun == 0 && byte_out == 0,
          "R9 reset outputs", {byte_valid, framing_error, overrun}, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R2: normal bytes
    send_byte(8'hA5);
    send_byte(8'h3C);
    send_byte(8'hFF);
    send_byte(8'h11);

    // R3: long idle produces nothing
    hold(4'h0, 60);
    check(exp_q.size() == 0 && ferr_count == 0, "R3 idle ignored", ferr_count, 0);

    // R1: latency of the high nibble
    exp_q.push_back(8'h4B);
    hold(4'hB, 20); hold(4'h0, 12);
    nib_in = 4'h4;
    repeat (STABLE + 2) @(negedge clk);
    check(byte_valid == 0, "R1 too early", byte_valid, 0);
    @(negedge clk);
    check(byte_valid == 1, "R1 latency", byte_valid, 1);
    hold(4'h4, 10); hold(4'h0, 12);

    // R4: short passing codes and a short pulse are ignored
    hold(4'h7, 4); hold(4'h0, 12);
    exp_q.push_back(8'h96);
    hold(4'h2, 3); hold(4'h6, 20); hold(4'h0, 12);
    hold(4'hD, 5); hold(4'h9, 20); hold(4'h0, 12);
    check(exp_q.size() == 0 && ferr_count == 0, "R4 glitches ignored", exp_q.size(), 0);

    // R5: long hold counts once; direct change without idle rejected
    exp_q.push_back(8'h2E);
    hold(4'hE, 100); hold(4'h0, 12);
    hold(4'h2, 100); hold(4'h0, 12);
    exp_q.push_back(8'h35);
    hold(4'h5, 20); hold(4'h9, 20); hold(4'h0, 12);
    hold(4'h3, 20); hold(4'h0, 12);
    check(exp_q.size() == 0, "R5 single acceptance", exp_q.size(), 0);

    // R6: low nibble times out, then recovery
    hold(4'h8, 20); hold(4'h0, TIMEOUT + 40);
    check(ferr_count == 1, "R6 timeout pulse", ferr_count, 1);
    send_byte(8'h7E);
    check(exp_q.size() == 0 && ferr_count == 1, "R6 recovery", exp_q.size(), 0);

    // R8: overrun
    byte_ready = 1'b0;
    send_byte(8'h21);
    check(overrun == 0, "R8 first byte no overrun", overrun, 0);
    send_byte(8'h43);
    check(overrun == 1, "R8 overrun set", overrun, 1);
    byte_ready = 1'b1;
    repeat (20) @(negedge clk);
    check(overrun == 1, "R8 overrun sticky", overrun, 1);

    // R9: reset clears the flag
    do_reset();
    check(overrun == 0, "R9 overrun cleared", overrun, 0);

    send_byte(8'hC7);
    check(exp_q.size() == 0, "R2 after reset", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule